// File: doc/BRIEF.md
# I2C Configuration Register Target

This block is an I2C target that holds a small bank of 8-bit configuration registers and presents them as parallel outputs to the rest of the chip. SCL and SDA are brought into the system clock domain through a synchronizer and oversampled. START, repeated START and STOP are recognised from SDA edges while SCL is high. The block drives SDA only through an output-enable that pulls the wire low, so the pad remains open-drain.

A bus master first addresses the device with a write, then sends a register pointer, then sends one or more data bytes. To read, the master writes the pointer, issues a repeated START, and addresses the device again with the read bit set. A register changes only on the SCL rising edge of the acknowledge that follows its data byte. The change is signalled by a single-cycle strobe together with the register index.

Top module: `i2c_cfg_target`

## Requirements
- R1: After reset, `sda_oe` is 0, every register output is 8'h00 and `upd_stb` is 0.
- R2: Each byte is taken MSB first. The first byte after a START or repeated START is a 7-bit address followed by a direction bit (0 = write, 1 = read). An address equal to 7'h38 is acknowledged by pulling SDA low throughout the ninth SCL pulse.
- R3: A first byte whose address is not 7'h38 gets no acknowledge. SDA then stays released, and no register changes, until the next START or STOP.
- R4: In a write, the byte after the address is the register pointer and the byte after that is data for the pointed register. The target acknowledges both.
- R5: A data byte for register i reaches bits [8i+7:8i] of `cfg_regs` exactly 3 clock cycles after SCL rises in that byte's acknowledge pulse, and not earlier. In the same cycle `upd_stb` is 1 for exactly one cycle and `upd_idx` equals i.
- R6: A pointer of NUM_REGS or above is still acknowledged with its data byte, but the data is discarded, no strobe is raised, and a read from that pointer returns 8'h00.
- R7: After a pointer write, a repeated START and the address with bit 0 = 1, the target shifts out the pointed register MSB first. The target changes `sda_oe` only while SCL is low.
- R8: The target releases SDA during the master's acknowledge slot. If the master acknowledges, the same register byte is sent again. If the master does not acknowledge, SDA stays released until the next START or STOP.
- R9: A START or STOP at any point, including inside a byte, discards the partial byte and returns the target to address reception (START) or idle (STOP). The next transfer then works normally.
- R10: Further data bytes in the same write transfer each go to the same pointer (no auto-increment), and each raises its own strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | SCL wire level |
| sda_i | input | 1 | SDA wire level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| cfg_regs | output | 8*NUM_REGS | Register i occupies bits [8i+7:8i] |
| upd_stb | output | 1 | One-cycle pulse when a register is written |
| upd_idx | output | IDX_W | Index of the register written with the strobe |

## Verification
Each wire change crosses two synchronizer flops. The event that follows is registered one cycle later. So an update is due 3 clock cycles after SCL rises in the final acknowledge, and SDA drive changes 3 cycles after an SCL fall.

The bench drives the bus on falling clock edges and samples on falling clock edges. It checks that the register is still old after two rising edges, new with the strobe after the third, and the strobe gone after the fourth. All SDA samples are taken several cycles into the SCL high phase, well beyond the 3-cycle latency.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_REG, ST_DATA, ST_ACK, ST_TX, ST_MACK, ST_IGNORE
  } i2c_st_e;

  typedef enum logic [1:0] {
    AK_ADDR_W, AK_ADDR_R, AK_REG, AK_DATA
  } ack_kind_e;

  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

  function automatic logic ptr_valid(input logic [7:0] p, input int unsigned n);
    return {24'd0, p} < n;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  // SDA edges only count while SCL stays high across both samples
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_cfg_fsm.sv
module i2c_cfg_fsm
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h38,
  parameter int NUM_REGS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic [7:0] ptr
);
  i2c_st_e   state_q;
  ack_kind_e kind_q;
  logic [3:0] bit_cnt_q;
  logic [7:0] shreg_q;
  logic [7:0] ptr_q;
  logic       oe_q;
  logic       m_ack_q;
  logic       byte_done;

  assign byte_done = scl_fall && (bit_cnt_q == 4'd8);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      kind_q    <= AK_ADDR_W;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      ptr_q     <= '0;
      oe_q      <= 1'b0;
      m_ack_q   <= 1'b0;
    end else if (start_ev) begin
      state_q   <= ST_ADDR;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else if (stop_ev) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_REG, ST_DATA: begin
          if (scl_rise && bit_cnt_q != 4'd8) begin
            shreg_q   <= {shreg_q[6:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (byte_done) begin
            if (state_q == ST_ADDR) begin
              if (addr_hit(shreg_q, DEV_ADDR)) begin
                oe_q    <= 1'b1;
                state_q <= ST_ACK;
                kind_q  <= shreg_q[0] ? AK_ADDR_R : AK_ADDR_W;
              end else begin
                state_q <= ST_IGNORE;
              end
            end else begin
              oe_q    <= 1'b1;
              state_q <= ST_ACK;
              if (state_q == ST_REG) begin
                ptr_q  <= shreg_q;
                kind_q <= AK_REG;
              end else begin
                kind_q <= AK_DATA;
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bit_cnt_q <= '0;
            unique case (kind_q)
              AK_ADDR_W: begin state_q <= ST_REG;  oe_q <= 1'b0; end
              AK_REG:    begin state_q <= ST_DATA; oe_q <= 1'b0; end
              AK_DATA:   begin state_q <= ST_DATA; oe_q <= 1'b0; end
              AK_ADDR_R: begin
                state_q <= ST_TX;
                shreg_q <= {rd_data[6:0], 1'b0};
                oe_q    <= ~rd_data[7];
              end
              default: state_q <= ST_IGNORE;
            endcase
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (bit_cnt_q == 4'd8) begin
              oe_q    <= 1'b0;
              state_q <= ST_MACK;
            end else begin
              oe_q    <= ~shreg_q[7];
              shreg_q <= {shreg_q[6:0], 1'b0};
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            m_ack_q <= ~sda_s;
          end else if (scl_fall) begin
            if (m_ack_q) begin
              state_q   <= ST_TX;
              bit_cnt_q <= '0;
              shreg_q   <= {rd_data[6:0], 1'b0};
              oe_q      <= ~rd_data[7];
            end else begin
              state_q <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // commit on the SCL rise inside the data byte's acknowledge
  assign wr_en   = (state_q == ST_ACK) && (kind_q == AK_DATA) && scl_rise &&
                   ptr_valid(ptr_q, NUM_REGS) && !start_ev && !stop_ev;
  assign wr_data = shreg_q;
  assign ptr     = ptr_q;
  assign sda_oe  = oe_q;

  // R9
  start_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (state_q == ST_ADDR) && (bit_cnt_q == 4'd0) && !oe_q);

  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (state_q == ST_IDLE) && !oe_q);

  // R3
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE) |-> !oe_q && !wr_en);

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import i2c_cfg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            wr_ptr,
  input  logic [7:0]            wr_data,
  input  logic [7:0]            rd_ptr,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] regs_flat,
  output logic                  upd_stb,
  output logic [IDX_W-1:0]      upd_idx
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else if (wr_en && wr_ptr == 8'(g)) q <= wr_data;
    end
    assign regs_flat[g*8 +: 8] = q;
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (rd_ptr == 8'(k)) rd_data = regs_flat[k*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_stb <= 1'b0;
      upd_idx <= '0;
    end else begin
      upd_stb <= wr_en;
      if (wr_en) upd_idx <= wr_ptr[IDX_W-1:0];
    end
  end

  // R6
  wr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ptr_valid(wr_ptr, NUM_REGS));

  // R5
  stb_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> !upd_stb);

endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target #(
  parameter logic [6:0] DEV_ADDR = 7'h38,
  parameter int NUM_REGS = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] cfg_regs,
  output logic                  upd_stb,
  output logic [IDX_W-1:0]      upd_idx
);
  logic scl_s_w, sda_s_w, scl_rise_w, scl_fall_w, start_w, stop_w;
  logic wr_en_w;
  logic [7:0] wr_data_w, ptr_w, rd_data_w;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s_w), .sda_s(sda_s_w), .scl_rise(scl_rise_w),
    .scl_fall(scl_fall_w), .start_ev(start_w), .stop_ev(stop_w)
  );

  i2c_cfg_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s_w), .scl_rise(scl_rise_w),
    .scl_fall(scl_fall_w), .start_ev(start_w), .stop_ev(stop_w),
    .rd_data(rd_data_w), .sda_oe(sda_oe), .wr_en(wr_en_w),
    .wr_data(wr_data_w), .ptr(ptr_w)
  );

  i2c_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_w), .wr_ptr(ptr_w),
    .wr_data(wr_data_w), .rd_ptr(ptr_w), .rd_data(rd_data_w),
    .regs_flat(cfg_regs), .upd_stb(upd_stb), .upd_idx(upd_idx)
  );

  // R5
  stb_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> $past(scl_rise_w));

  // R7
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(scl_s_w) |-> $stable(sda_oe));

endmodule

// File: tb/sim_i2c_cfg_target.sv
module sim_i2c_cfg_target;
  localparam int NREG = 8;
  localparam int Q = 6;
  localparam int H = 8;
  localparam logic [6:0] DEV = 7'h38;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] cfg_regs;
  logic upd_stb;
  logic [2:0] upd_idx;
  logic sda_line;

  int checks = 0;
  int fails = 0;
  int stb_cnt = 0;
  int r7_bad = 0;
  bit done = 1'b0;
  logic scl_prev = 1'b1;
  logic oe_prev = 1'b0;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_cfg_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .cfg_regs(cfg_regs), .upd_stb(upd_stb), .upd_idx(upd_idx)
  );

  always @(negedge clk) begin
    if (upd_stb) stb_cnt++;
    if (scl_m && scl_prev && sda_oe != oe_prev) r7_bad++;
    scl_prev = scl_m;
    oe_prev  = sda_oe;
  end

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37) ^ 8'hA5);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b0; wt(H); scl_m = 1'b0;
  endtask

  task automatic bus_rstart();
    wt(2); sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wt(2); sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      wt(2); sda_m = b[i]; wt(Q); scl_m = 1'b1; wt(H); scl_m = 1'b0;
    end
  endtask

  // byte plus ack slot; optional commit timing check on register idx
  task automatic send_byte(input logic [7:0] b, output logic nack, input bit cc,
                           input int idx, input logic [7:0] old_v, input logic [7:0] new_v);
    send_bits(b, 8);
    wt(2); sda_m = 1'b1; wt(Q); scl_m = 1'b1;
    nack = 1'b1;
    for (int k = 1; k <= H; k++) begin
      @(negedge clk);
      if (cc && k == 2) begin
        // R5 not yet committed after two rising clock edges
        chk(cfg_regs[idx*8 +: 8] == old_v && !upd_stb, "R5 early", cfg_regs[idx*8 +: 8], old_v);
      end
      if (cc && k == 3) begin
        // R5 committed with strobe on the third edge
        chk(cfg_regs[idx*8 +: 8] == new_v, "R5 value", cfg_regs[idx*8 +: 8], new_v);
        chk(upd_stb && upd_idx == 3'(idx), "R5 strobe/idx", {upd_stb, upd_idx}, {1'b1, 3'(idx)});
      end
      if (cc && k == 4) chk(!upd_stb, "R5 strobe width", upd_stb, 0);
      if (k == 4) nack = sda_line;
    end
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic m_nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      wt(2); sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(H/2); d[i] = sda_line; wt(H/2); scl_m = 1'b0;
    end
    wt(2); sda_m = m_nack; wt(Q); scl_m = 1'b1; wt(H/2);
    // R8 target released during master ack slot
    chk(!sda_oe, "R8 release in master ack", sda_oe, 0);
    wt(H/2); scl_m = 1'b0; wt(2); sda_m = 1'b1;
  endtask

  task automatic write_reg(input logic [7:0] p, input logic [7:0] v, input bit cc,
                           input logic [7:0] old_v);
    logic n;
    bus_start();
    send_byte({DEV, 1'b0}, n, 1'b0, 0, 8'h00, 8'h00);
    chk(!n, "R2 address ack", n, 0);
    send_byte(p, n, 1'b0, 0, 8'h00, 8'h00);
    chk(!n, "R4 pointer ack", n, 0);
    send_byte(v, n, cc, int'(p), old_v, v);
    chk(!n, "R4 data ack", n, 0);
    bus_stop();
    wt(H);
  endtask

  task automatic read_reg(input logic [7:0] p, output logic [7:0] d);
    logic n;
    bus_start();
    send_byte({DEV, 1'b0}, n, 1'b0, 0, 8'h00, 8'h00);
    send_byte(p, n, 1'b0, 0, 8'h00, 8'h00);
    bus_rstart();
    send_byte({DEV, 1'b1}, n, 1'b0, 0, 8'h00, 8'h00);
    chk(!n, "R7 read address ack", n, 0);
    recv_byte(1'b1, d);
    bus_stop();
    wt(H);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d, d2;
    logic n;
    int s0;
    wt(5); rst_n = 1'b1; wt(5);
    // R1 reset state
    chk(!sda_oe && cfg_regs == '0 && !upd_stb, "R1 reset state", cfg_regs, 0);

    // R4 R5 write every register with commit timing
    for (int i = 0; i < NREG; i++) write_reg(8'(i), pat(i), 1'b1, 8'h00);
    for (int i = 0; i < NREG; i++)
      chk(cfg_regs[i*8 +: 8] == pat(i), "R4 register contents", cfg_regs[i*8 +: 8], pat(i));
    chk(stb_cnt == NREG, "R5 strobe count", stb_cnt, NREG);

    // R7 read back each register
    for (int i = 0; i < NREG; i++) begin
      read_reg(8'(i), d);
      chk(d == pat(i), "R7 read data", d, pat(i));
    end

    // R3 sweep of every other address
    s0 = stb_cnt;
    for (int a = 0; a < 128; a++) begin
      if (a == int'(DEV)) continue;
      bus_start();
      send_byte({7'(a), 1'b0}, n, 1'b0, 0, 8'h00, 8'h00);
      send_byte(8'h00, d[0], 1'b0, 0, 8'h00, 8'h00);
      chk(n && d[0], "R3 no ack for other address", {n, d[0]}, 2'b11);
      bus_stop();
    end
    chk(stb_cnt == s0, "R3 no strobe", stb_cnt, s0);
    for (int i = 0; i < NREG; i++)
      chk(cfg_regs[i*8 +: 8] == pat(i), "R3 registers kept", cfg_regs[i*8 +: 8], pat(i));

    // R6 out-of-range pointers
    s0 = stb_cnt;
    write_reg(8'd8, 8'h5A, 1'b0, 8'h00);
    write_reg(8'hFF, 8'h5A, 1'b0, 8'h00);
    chk(stb_cnt == s0, "R6 no strobe", stb_cnt, s0);
    for (int i = 0; i < NREG; i++)
      chk(cfg_regs[i*8 +: 8] == pat(i), "R6 registers kept", cfg_regs[i*8 +: 8], pat(i));
    read_reg(8'd8, d);
    chk(d == 8'h00, "R6 read returns zero", d, 0);

    // R10 two data bytes in one transfer
    s0 = stb_cnt;
    bus_start();
    send_byte({DEV, 1'b0}, n, 1'b0, 0, 8'h00, 8'h00);
    send_byte(8'd2, n, 1'b0, 0, 8'h00, 8'h00);
    send_byte(8'h11, n, 1'b1, 2, pat(2), 8'h11);
    send_byte(8'h22, n, 1'b1, 2, 8'h11, 8'h22);
    bus_stop(); wt(H);
    chk(cfg_regs[2*8 +: 8] == 8'h22 && cfg_regs[3*8 +: 8] == pat(3), "R10 same pointer",
        cfg_regs[2*8 +: 8], 8'h22);
    chk(stb_cnt == s0 + 2, "R10 strobe per byte", stb_cnt, s0 + 2);

    // R8 master ack repeats byte, then nack then silence
    bus_start();
    send_byte({DEV, 1'b0}, n, 1'b0, 0, 8'h00, 8'h00);
    send_byte(8'd5, n, 1'b0, 0, 8'h00, 8'h00);
    bus_rstart();
    send_byte({DEV, 1'b1}, n, 1'b0, 0, 8'h00, 8'h00);
    recv_byte(1'b0, d);
    recv_byte(1'b1, d2);
    chk(d == pat(5) && d2 == pat(5), "R8 repeat after master ack", d2, pat(5));
    recv_byte(1'b1, d);
    chk(d == 8'hFF, "R8 released after master nack", d, 8'hFF);
    bus_stop(); wt(H);

    // R9 stop inside a data byte
    s0 = stb_cnt;
    bus_start();
    send_byte({DEV, 1'b0}, n, 1'b0, 0, 8'h00, 8'h00);
    send_byte(8'd3, n, 1'b0, 0, 8'h00, 8'h00);
    send_bits(8'h0F, 4);
    bus_stop(); wt(H);
    chk(stb_cnt == s0 && cfg_regs[3*8 +: 8] == pat(3), "R9 partial byte dropped",
        cfg_regs[3*8 +: 8], pat(3));
    // R9 repeated start inside an address byte, then full write
    bus_start();
    send_bits({DEV, 1'b0}, 3);
    bus_rstart();
    send_byte({DEV, 1'b0}, n, 1'b0, 0, 8'h00, 8'h00);
    chk(!n, "R9 address after restart", n, 0);
    send_byte(8'd3, n, 1'b0, 0, 8'h00, 8'h00);
    send_byte(8'h3C, n, 1'b1, 3, pat(3), 8'h3C);
    bus_stop(); wt(H);
    read_reg(8'd3, d);
    chk(d == 8'h3C, "R9 recovered write and read", d, 8'h3C);

    // R7 target drive never changed while SCL high
    chk(r7_bad == 0, "R7 drive changes with SCL high", r7_bad, 0);

    done = 1'b1;
    finish_run();
  end

endmodule